// File: doc/BRIEF.md
# Memory-Type-Aware Write Buffer

This block sits between a processor-side write port and an interconnect-side write port. It decides, for each write, at which point completion is reported back to the requester. Writes tagged as buffered (device or normal) are acknowledged one cycle after they enter a small internal FIFO, before they have gone downstream. Writes tagged strongly-ordered are held in a side register and are acknowledged only once the endpoint has answered, so that their error status comes back with the acknowledgement.

Order is kept only among writes to the same peripheral region, where the region is the upper half of the address. A strongly-ordered write may overtake buffered writes to other regions, but it waits behind any buffered write to its own region. An endpoint error on a buffered write cannot travel with its acknowledgement. It raises a sticky flag that holds the address of the first such failure until software clears it. A drain status output tells a barrier when nothing is left buffered, pending or in flight.

Top module: `memtype_write_buffer`

## Requirements
- R1: A write with `req_kind` 2'b00 (normal) or 2'b01 (device) is acknowledged by a one-cycle `req_done` pulse in the cycle after its handshake, with `req_err` low.
- R2: A write with `req_kind[1]` set (strongly-ordered) raises `req_done` only in the cycle after the endpoint response for that write, and `req_err` then equals the endpoint error bit.
- R3: While a strongly-ordered write is awaiting completion, `req_ready` stays low for every kind of write.
- R4: Writes whose addresses agree in bits [31:16] leave on the downstream port in the order they were accepted.
- R5: A strongly-ordered write to a region with no buffered writes is issued downstream ahead of buffered writes to other regions, once the write already in flight has been answered.
- R6: A strongly-ordered write is not issued while any buffered write to its own region remains in the FIFO.
- R7: The FIFO holds DEPTH writes plus one in flight. With the downstream stalled, exactly DEPTH+1 buffered writes are accepted before `req_ready` falls.
- R8: At most one downstream write is outstanding. `dn_valid` stays high with stable `dn_addr` and `dn_data` until `dn_ready` is seen.
- R9: An endpoint error on a buffered write sets `async_err` and records its address in `async_err_addr`. Later errors leave both unchanged while the flag is set.
- R10: A pulse on `err_clear` drops `async_err`, and a later buffered error captures its own address.
- R11: `drain_done` is high only when the FIFO is empty, nothing is in flight downstream and no strongly-ordered write is pending.
- R12: After reset `req_ready` and `drain_done` are high, and `dn_valid`, `req_done` and `async_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester write valid |
| req_ready | output | 1 | Write accepted when high with `req_valid` |
| req_kind | input | 2 | 00 normal, 01 device, 1x strongly-ordered |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_done | output | 1 | Completion pulse to requester |
| req_err | output | 1 | Error with completion (strongly-ordered only) |
| dn_valid | output | 1 | Downstream write valid |
| dn_ready | input | 1 | Downstream accepts write |
| dn_addr | output | AW | Downstream address |
| dn_data | output | DW | Downstream data |
| dn_resp_valid | input | 1 | Endpoint response pulse |
| dn_resp_err | input | 1 | Endpoint error with response |
| drain_done | output | 1 | Nothing buffered, pending or in flight |
| async_err | output | 1 | Sticky error flag for buffered writes |
| async_err_addr | output | AW | Address of first failing buffered write |
| err_clear | input | 1 | Clears the sticky error flag |

## Verification
The bench keeps the default DEPTH of 4, 32-bit addresses and data, and a region boundary at bit 16. At that depth a stall of five writes reaches the full condition in a handful of cycles. With 16-bit region tags, regions can be told apart by a single address digit, so overtaking and same-region waiting can be set up from three writes with a stalled endpoint. A behavioural endpoint answers two cycles after each handshake and flags an error when data bit 31 is set. Because of this, both the synchronous and the sticky error paths come from ordinary vectors.

// File: rtl/memtype_write_buffer.sv
module memtype_write_buffer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int REGION_LSB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_done,
  output logic          req_err,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_data,
  input  logic          dn_resp_valid,
  input  logic          dn_resp_err,
  output logic          drain_done,
  output logic          async_err,
  output logic [AW-1:0] async_err_addr,
  input  logic          err_clear
);
  // DEPTH must be a power of two, at least 2
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  logic          so_pend;
  logic [AW-1:0] so_addr;
  logic [DW-1:0] so_data;

  logic          out_busy, out_sent, out_so;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  logic is_so_req, full, empty, acc, push, so_take;
  logic region_hit, resp, issue_so, issue_q;

  assign is_so_req = req_kind[1];
  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign req_ready = !so_pend && (is_so_req || !full);
  assign acc       = req_valid && req_ready;
  assign push      = acc && !is_so_req;
  assign so_take   = acc && is_so_req;
  assign resp      = out_busy && out_sent && dn_resp_valid;
  assign issue_so  = !out_busy && so_pend && !region_hit;
  assign issue_q   = !out_busy && !empty && !issue_so;

  always_comb begin
    region_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] offs;
      offs = PW'(i) - rd_ptr;
      if ((CW'(offs) < cnt) &&
          (q_addr[i][AW-1:REGION_LSB] == so_addr[AW-1:REGION_LSB]))
        region_hit = 1'b1;
    end
  end

  assign dn_valid   = out_busy && !out_sent;
  assign dn_addr    = out_addr;
  assign dn_data    = out_data;
  assign drain_done = empty && !out_busy && !so_pend;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= req_addr;
      q_data[wr_ptr] <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push)    wr_ptr <= wr_ptr + 1'b1;
      if (issue_q) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(issue_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_pend <= 1'b0;
      so_addr <= '0;
      so_data <= '0;
    end else if (so_take) begin
      so_pend <= 1'b1;
      so_addr <= req_addr;
      so_data <= req_data;
    end else if (resp && out_so) begin
      so_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_busy <= 1'b0;
      out_sent <= 1'b0;
      out_so   <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else if (issue_so || issue_q) begin
      out_busy <= 1'b1;
      out_sent <= 1'b0;
      out_so   <= issue_so;
      out_addr <= issue_so ? so_addr : q_addr[rd_ptr];
      out_data <= issue_so ? so_data : q_data[rd_ptr];
    end else if (resp) begin
      out_busy <= 1'b0;
      out_sent <= 1'b0;
    end else if (dn_valid && dn_ready) begin
      out_sent <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_done <= 1'b0;
      req_err  <= 1'b0;
    end else begin
      req_done <= push || (resp && out_so);
      req_err  <= resp && out_so && dn_resp_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_err      <= 1'b0;
      async_err_addr <= '0;
    end else if (resp && !out_so && dn_resp_err && (!async_err || err_clear)) begin
      async_err      <= 1'b1;
      async_err_addr <= out_addr;
    end else if (err_clear) begin
      async_err <= 1'b0;
    end
  end

  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> ($past(req_valid && req_ready && !req_kind[1]) || $past(dn_resp_valid)));

  p_so_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    so_pend |-> !req_ready);

  p_so_own_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && out_so) |-> !region_hit);

  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !req_kind[1]) |-> !req_ready);

  p_dn_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (async_err && !err_clear) |=> (async_err && $stable(async_err_addr)));

  p_drain_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> (!dn_valid && req_ready));
endmodule

// File: tb/tb_memtype_write_buffer.sv
module tb_memtype_write_buffer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int NV = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, dn_ready = 0, dn_resp_valid = 0, dn_resp_err = 0, err_clear = 0;
  logic [1:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic req_ready, req_done, req_err, dn_valid, drain_done, async_err;
  logic [AW-1:0] dn_addr, async_err_addr;
  logic [DW-1:0] dn_data;

  always #5 clk = ~clk;

  memtype_write_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .REGION_LSB(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .req_done(req_done), .req_err(req_err), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_data(dn_data), .dn_resp_valid(dn_resp_valid),
    .dn_resp_err(dn_resp_err), .drain_done(drain_done), .async_err(async_err),
    .async_err_addr(async_err_addr), .err_clear(err_clear));

  // kind, addr, data ; data bit 31 makes the endpoint return an error
  localparam logic [65:0] VEC [NV] = '{
    {2'b01, 32'h0001_0000, 32'h0000_0010},
    {2'b01, 32'h0001_0004, 32'h0000_0011},
    {2'b00, 32'h0002_0000, 32'h0000_0012},
    {2'b10, 32'h0001_0008, 32'h0000_0013},
    {2'b01, 32'h0003_0000, 32'h8000_0014},
    {2'b10, 32'h0002_0004, 32'h8000_0015},
    {2'b01, 32'h0003_0004, 32'h8000_0016},
    {2'b01, 32'h0002_0008, 32'h0000_0017},
    {2'b11, 32'h0004_0000, 32'h0000_0018},
    {2'b01, 32'h0001_000C, 32'h0000_0019}
  };

  int checks = 0, fails = 0;
  logic ep_ready = 1;
  int resp_cnt = 0;
  logic last_err = 0;
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int log_n = 0;
  logic [DW-1:0] resp_data [64];
  int resp_n = 0;

  // behavioural endpoint: answers two cycles after each handshake
  always @(negedge clk) begin
    dn_resp_valid = 0;
    dn_resp_err = 0;
    if (resp_cnt != 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        dn_resp_valid = 1;
        dn_resp_err = last_err;
        resp_data[resp_n] = log_data[log_n-1];
        resp_n++;
      end
    end
    dn_ready = ep_ready;
    if (dn_valid && dn_ready && log_n < 64) begin
      log_addr[log_n] = dn_addr;
      log_data[log_n] = dn_data;
      log_n++;
      last_err = dn_data[31];
      resp_cnt = 2;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic do_write(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!k[1]) begin
      chk(req_done && !req_err, "R1 buffered ack", {req_done, req_err}, 2'b10);
    end else begin
      if (!req_done) chk(!req_ready, "R3 ready low while ordered write pends", req_ready, 0);
      while (!req_done) @(negedge clk);
      chk(resp_n > 0 && resp_data[resp_n-1] == d, "R2 ack after endpoint response",
          resp_n > 0 ? resp_data[resp_n-1] : 0, d);
      chk(req_err == d[31], "R2 synchronous error", req_err, d[31]);
    end
  endtask

  task automatic wait_drain();
    int n = 0;
    @(negedge clk);
    while (!drain_done && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    fails++; checks++;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready && drain_done && !dn_valid && !req_done && !async_err, "R12 reset state",
        {req_ready, drain_done, dn_valid, req_done, async_err}, 5'b11000);

    for (int i = 0; i < NV; i++)
      do_write(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
    wait_drain();
    chk(drain_done, "R11 drained after table", drain_done, 1);
    chk(log_n == NV, "R4 all writes left", log_n, NV);
    // R9 first buffered failure recorded, second left alone
    chk(async_err && async_err_addr == 32'h0003_0000, "R9 sticky first error",
        async_err_addr, 32'h0003_0000);

    // R10 clear then capture a new address
    @(negedge clk); err_clear = 1;
    @(negedge clk); err_clear = 0;
    chk(!async_err, "R10 flag cleared", async_err, 0);
    do_write(2'b01, 32'h0008_0000, 32'h8000_0020);
    wait_drain();
    chk(async_err && async_err_addr == 32'h0008_0000, "R10 new error captured",
        async_err_addr, 32'h0008_0000);

    // R5 ordered write to another region overtakes a buffered one
    begin
      int base;
      base = log_n;
      ep_ready = 0;
      do_write(2'b01, 32'h0005_0000, 32'h0000_0021);
      do_write(2'b01, 32'h0005_0004, 32'h0000_0022);
      chk(!drain_done, "R11 not drained while stalled", drain_done, 0);
      fork
        do_write(2'b10, 32'h0006_0000, 32'h0000_0023);
        begin repeat (4) @(negedge clk); ep_ready = 1; end
      join
      wait_drain();
      chk(log_data[base+1] == 32'h23, "R5 ordered write overtakes other region",
          log_data[base+1], 32'h23);
      chk(log_data[base+2] == 32'h22, "R5 buffered write follows", log_data[base+2], 32'h22);
    end

    // R6 ordered write to the same region waits
    begin
      int base;
      base = log_n;
      ep_ready = 0;
      do_write(2'b01, 32'h0005_0010, 32'h0000_0024);
      do_write(2'b01, 32'h0005_0014, 32'h0000_0025);
      fork
        do_write(2'b10, 32'h0005_0018, 32'h0000_0026);
        begin repeat (4) @(negedge clk); ep_ready = 1; end
      join
      wait_drain();
      chk(log_data[base+1] == 32'h25 && log_data[base+2] == 32'h26,
          "R6 ordered write waits for own region", log_data[base+2], 32'h26);
    end

    // R7 and R8 with the endpoint stalled
    begin
      int accepted, base;
      logic held_ok;
      accepted = 0; held_ok = 1;
      base = log_n;
      ep_ready = 0;
      @(negedge clk);
      req_valid = 1; req_kind = 2'b01;
      req_addr = 32'h0007_0000; req_data = 32'h30;
      for (int k = 0; k < 10; k++) begin
        if (req_ready) accepted++;
        @(negedge clk);
        req_addr = 32'h0007_0000 + 32'(accepted * 4);
        req_data = 32'h30 + 32'(accepted);
        if (k > 2 && !(dn_valid && dn_addr == 32'h0007_0000)) held_ok = 0;
      end
      req_valid = 0;
      chk(accepted == DEPTH + 1, "R7 accepted before backpressure", accepted, DEPTH + 1);
      chk(!req_ready, "R7 ready low when full", req_ready, 0);
      chk(held_ok, "R8 downstream write held while stalled", held_ok, 1);
      ep_ready = 1;
      wait_drain();
      chk(log_n == base + DEPTH + 1, "R8 one at a time, all delivered", log_n - base, DEPTH + 1);
    end

    // R4 order within every region over the whole run
    begin
      logic ord_ok;
      ord_ok = 1;
      for (int i = 0; i < log_n; i++)
        for (int j = i + 1; j < log_n; j++)
          if (log_addr[i][31:16] == log_addr[j][31:16] && log_data[i][7:0] > log_data[j][7:0])
            ord_ok = 0;
      chk(ord_ok, "R4 same-region order kept", ord_ok, 1);
    end
    summary();
  end
endmodule